// File: doc/BRIEF.md
# Windowed DRAM Page Mapper

This block sits between a small processor with a 16-bit data address space and a DRAM that is larger than that space. The lower fifteen 4 KB windows of the processor space (0x0000 to 0xEFFF) each look through to a DRAM page chosen by its own page-select register. Every access to a window therefore leaves the block as a wider DRAM address: the window's page number followed by the 12-bit offset inside the window. The top window (0xF000 to 0xFFFF) holds control locations and never reaches the DRAM.

The page-select registers are 16 bits wide and are loaded one byte at a time from the processor bus, low byte first in address order. They can be read back. Two write-only strobe locations switch DRAM writes off and on again. This lets firmware keep the DRAM quiet while other devices on the same bus take write cycles. Address translation is combinational, so the DRAM address, select and write enable follow the processor bus within the same cycle. Register and strobe updates take effect on the next clock edge.

Top module: `dram_window_mapper`

## Requirements
- R1: After reset, page-select register n holds the value n. Window n therefore maps to DRAM page n, which gives the identity mapping.
- R2: An access with cpu_addr[15:12] = 0xF never raises dram_sel or dram_we, whether it is a read or a write.
- R3: A read or write to window w (w = cpu_addr[15:12], 0 to 14) raises dram_sel in the same cycle. dram_addr is then {low DRAM_PAGE_BITS bits of page register w, cpu_addr[11:0]}. With neither strobe active, dram_sel is low.
- R4: A write to byte address 0xFF00 + 2w loads bits 7:0 of page register w, and a write to 0xFF01 + 2w loads bits 15:8. The new value is used for translation from the next cycle on.
- R5: A read at 0xFF00 to 0xFF1D returns on cpu_rdata the stored register byte, with the low byte at the even address. Reads of any other address, and cycles without cpu_rd, return 0.
- R6: After any data byte is written to 0xFFC0, a write to a mapped window raises dram_sel but leaves dram_we low. Reads still select and translate normally.
- R7: After any data byte is written to 0xFFC1, writes to mapped windows raise dram_we again. Right after reset, DRAM writes are allowed.
- R8: Page register bits at and above DRAM_PAGE_BITS are stored and can be read back, but they do not affect dram_addr.
- R9: A page register byte write changes only the addressed byte. The other byte of that register and all other registers keep their values.
- R10: dram_we is high only in a cycle where cpu_wr is high. A read alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Page register readback byte |
| dram_addr | output | 22 | DRAM byte address (page and offset) |
| dram_sel | output | 1 | DRAM access select |
| dram_we | output | 1 | Qualified DRAM write enable |

## Verification
The bench builds the block with its default parameters: 16-bit processor address, 12-bit window offset, 16-bit page registers in two byte lanes, and DRAM_PAGE_BITS of 10. Ten page bits leave six stored bits above the DRAM address. A high-byte write can therefore show at once that the lower two bits of the high byte reach dram_addr and that the upper six are dropped, while readback still returns the full byte. Fifteen windows with a two-byte stride put the last register byte at 0xFF1D, so the first unmapped register address, 0xFF1E, sits right next to it and is checked to read zero.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   // Decode result for one processor address.
   typedef struct packed {
      logic mapped;   // address falls in a DRAM-backed window
      logic cfg_hit;  // address falls on a page register byte
      logic dis_hit;  // write-block strobe location
      logic en_hit;   // write-allow strobe location
   } map_hit_t;

   // True when the bus carries any access this cycle.
   function automatic logic bus_active(input logic rd, input logic wr);
      return rd | wr;
   endfunction

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
   import mapper_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFFSET_W  = 12,
   parameter int NUM_WIN   = 15,
   parameter int BYTES     = 2,
   parameter int IDX_W     = ADDR_W - OFFSET_W,
   parameter int REG_IDX_W = $clog2(NUM_WIN),
   parameter int LANE_W    = $clog2(BYTES),
   parameter logic [ADDR_W-1:0] CFG_BASE    = 16'hFF00,
   parameter logic [ADDR_W-1:0] WR_DIS_ADDR = 16'hFFC0,
   parameter logic [ADDR_W-1:0] WR_EN_ADDR  = 16'hFFC1
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [IDX_W-1:0]     win_idx,
   output logic [REG_IDX_W-1:0] reg_idx,
   output logic [LANE_W-1:0]    reg_lane,
   output map_hit_t             hit
);

   localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(NUM_WIN * BYTES);

   logic [ADDR_W-1:0] cfg_off;

   always_comb begin
      win_idx     = addr[ADDR_W-1 -: IDX_W];
      cfg_off     = addr - CFG_BASE;
      reg_lane    = cfg_off[LANE_W-1:0];
      reg_idx     = cfg_off[LANE_W +: REG_IDX_W];
      hit.mapped  = (32'(win_idx) < NUM_WIN);
      hit.cfg_hit = (addr >= CFG_BASE) && (cfg_off < CFG_SPAN);
      hit.dis_hit = (addr == WR_DIS_ADDR);
      hit.en_hit  = (addr == WR_EN_ADDR);
   end

endmodule

// File: rtl/mapper_pagefile.sv
module mapper_pagefile #(
   parameter int NUM_WIN   = 15,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 16,
   parameter int OUT_W     = 10,
   parameter int IDX_W     = 4,
   parameter int BYTES     = PAGE_W / DATA_W,
   parameter int REG_IDX_W = $clog2(NUM_WIN),
   parameter int LANE_W    = $clog2(BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   // byte write port
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [LANE_W-1:0]    wr_lane,
   input  logic [DATA_W-1:0]    wr_data,
   // translation read port
   input  logic [IDX_W-1:0]     win_idx,
   output logic [OUT_W-1:0]     win_page,
   // byte readback port
   input  logic [REG_IDX_W-1:0] rb_idx,
   input  logic [LANE_W-1:0]    rb_lane,
   output logic [DATA_W-1:0]    rb_byte
);

   logic [PAGE_W-1:0] page_q [NUM_WIN];

   // One register per window; reset value is the window's own index.
   for (genvar g = 0; g < NUM_WIN; g++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            page_q[g] <= PAGE_W'(g);
         end else if (wr_en && (wr_idx == REG_IDX_W'(g))) begin
            for (int l = 0; l < BYTES; l++) begin
               if (wr_lane == LANE_W'(l))
                  page_q[g][l*DATA_W +: DATA_W] <= wr_data;
            end
         end
      end
   end

   // Translation port: truncated page of the addressed window.
   always_comb begin
      win_page = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (win_idx == IDX_W'(i))
            win_page = page_q[i][OUT_W-1:0];
      end
   end

   // Readback port: one byte lane of one register.
   always_comb begin
      rb_byte = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         for (int l = 0; l < BYTES; l++) begin
            if ((rb_idx == REG_IDX_W'(i)) && (rb_lane == LANE_W'(l)))
               rb_byte = page_q[i][l*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/mapper_wr_gate.sv
module mapper_wr_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic block_stb,
   input  logic allow_stb,
   output logic wr_allowed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_allowed <= 1'b1;
      else if (block_stb)
         wr_allowed <= 1'b0;
      else if (allow_stb)
         wr_allowed <= 1'b1;
   end

endmodule

// File: rtl/dram_window_mapper.sv
module dram_window_mapper
   import mapper_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int OFFSET_W       = 12,
   parameter int DATA_W         = 8,
   parameter int PAGE_W         = 16,
   parameter int DRAM_PAGE_BITS = 10,
   parameter logic [ADDR_W-1:0] CFG_BASE    = 16'hFF00,
   parameter logic [ADDR_W-1:0] WR_DIS_ADDR = 16'hFFC0,
   parameter logic [ADDR_W-1:0] WR_EN_ADDR  = 16'hFFC1,
   localparam int DRAM_ADDR_W   = DRAM_PAGE_BITS + OFFSET_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [DATA_W-1:0]      cpu_wdata,
   input  logic                   cpu_rd,
   input  logic                   cpu_wr,
   output logic [DATA_W-1:0]      cpu_rdata,
   output logic [DRAM_ADDR_W-1:0] dram_addr,
   output logic                   dram_sel,
   output logic                   dram_we
);

   localparam int IDX_W     = ADDR_W - OFFSET_W;
   localparam int NUM_WIN   = (1 << IDX_W) - 1;
   localparam int BYTES     = PAGE_W / DATA_W;
   localparam int REG_IDX_W = $clog2(NUM_WIN);
   localparam int LANE_W    = $clog2(BYTES);

   // Elaboration-time parameter checks.
   if (OFFSET_W >= ADDR_W || IDX_W < 1) begin : g_bad_offset
      $error("window offset must leave at least one window index bit");
   end
   if (BYTES < 2 || BYTES * DATA_W != PAGE_W || (1 << LANE_W) != BYTES) begin : g_bad_lanes
      $error("page register must be a power-of-two number of data bytes, at least two");
   end
   if (DRAM_PAGE_BITS < 1 || DRAM_PAGE_BITS > PAGE_W) begin : g_bad_page_bits
      $error("DRAM_PAGE_BITS must lie between 1 and the page register width");
   end
   if (CFG_BASE[ADDR_W-1 -: IDX_W] != {IDX_W{1'b1}}) begin : g_bad_cfg_base
      $error("page registers must sit in the unmapped top window");
   end

   logic [IDX_W-1:0]     win_idx;
   logic [REG_IDX_W-1:0] reg_idx;
   logic [LANE_W-1:0]    reg_lane;
   map_hit_t             hit;
   logic [DRAM_PAGE_BITS-1:0] win_page;
   logic [DATA_W-1:0]    rb_byte;
   logic                 wr_allowed;
   logic                 cfg_wr;

   mapper_decode #(
      .ADDR_W     (ADDR_W),
      .OFFSET_W   (OFFSET_W),
      .NUM_WIN    (NUM_WIN),
      .BYTES      (BYTES),
      .IDX_W      (IDX_W),
      .REG_IDX_W  (REG_IDX_W),
      .LANE_W     (LANE_W),
      .CFG_BASE   (CFG_BASE),
      .WR_DIS_ADDR(WR_DIS_ADDR),
      .WR_EN_ADDR (WR_EN_ADDR)
   ) i_decode (
      .addr    (cpu_addr),
      .win_idx (win_idx),
      .reg_idx (reg_idx),
      .reg_lane(reg_lane),
      .hit     (hit)
   );

   assign cfg_wr = cpu_wr && hit.cfg_hit;

   mapper_pagefile #(
      .NUM_WIN  (NUM_WIN),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .OUT_W    (DRAM_PAGE_BITS),
      .IDX_W    (IDX_W),
      .BYTES    (BYTES),
      .REG_IDX_W(REG_IDX_W),
      .LANE_W   (LANE_W)
   ) i_pagefile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_idx  (reg_idx),
      .wr_lane (reg_lane),
      .wr_data (cpu_wdata),
      .win_idx (win_idx),
      .win_page(win_page),
      .rb_idx  (reg_idx),
      .rb_lane (reg_lane),
      .rb_byte (rb_byte)
   );

   mapper_wr_gate i_wr_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .block_stb (cpu_wr && hit.dis_hit),
      .allow_stb (cpu_wr && hit.en_hit),
      .wr_allowed(wr_allowed)
   );

   always_comb begin
      dram_addr = {win_page, cpu_addr[OFFSET_W-1:0]};
      dram_sel  = bus_active(cpu_rd, cpu_wr) && hit.mapped;
      dram_we   = cpu_wr && hit.mapped && wr_allowed;
      cpu_rdata = (cpu_rd && hit.cfg_hit) ? rb_byte : '0;
   end

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int ADDR_W      = 16,
   parameter int OFFSET_W    = 12,
   parameter int DATA_W      = 8,
   parameter int DRAM_ADDR_W = 22,
   parameter logic [ADDR_W-1:0] CFG_BASE    = 16'hFF00,
   parameter logic [ADDR_W-1:0] WR_DIS_ADDR = 16'hFFC0,
   parameter logic [ADDR_W-1:0] WR_EN_ADDR  = 16'hFFC1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      cpu_addr,
   input logic [DATA_W-1:0]      cpu_wdata,
   input logic                   cpu_rd,
   input logic                   cpu_wr,
   input logic [DRAM_ADDR_W-1:0] dram_addr,
   input logic                   dram_sel,
   input logic                   dram_we
);

   localparam int IDX_W = ADDR_W - OFFSET_W;

   logic in_mapped;
   assign in_mapped = (cpu_addr[ADDR_W-1 -: IDX_W] != {IDX_W{1'b1}});

   assert_top_window_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_mapped |-> (!dram_sel && !dram_we));

   assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dram_sel |-> (dram_addr[OFFSET_W-1:0] == cpu_addr[OFFSET_W-1:0]));

   assert_low_byte_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == CFG_BASE) ##1 (cpu_rd && cpu_addr[ADDR_W-1 -: IDX_W] == '0)
      |-> (dram_addr[OFFSET_W] == $past(cpu_wdata[0])));

   assert_block_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == WR_DIS_ADDR) |=> !dram_we);

   assert_allow_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == WR_EN_ADDR) ##1 (cpu_wr && in_mapped) |-> dram_we);

   assert_we_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dram_we |-> (cpu_wr && dram_sel));

endmodule

bind dram_window_mapper mapper_checker #(
   .ADDR_W     (ADDR_W),
   .OFFSET_W   (OFFSET_W),
   .DATA_W     (DATA_W),
   .DRAM_ADDR_W(DRAM_ADDR_W),
   .CFG_BASE   (CFG_BASE),
   .WR_DIS_ADDR(WR_DIS_ADDR),
   .WR_EN_ADDR (WR_EN_ADDR)
) i_mapper_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .cpu_wdata(cpu_wdata),
   .cpu_rd   (cpu_rd),
   .cpu_wr   (cpu_wr),
   .dram_addr(dram_addr),
   .dram_sel (dram_sel),
   .dram_we  (dram_we)
);

// File: tb/test_dram_window_mapper.sv
`timescale 1ns/1ps
module test_dram_window_mapper;

   localparam int PB = 10;
   localparam int AW = PB + 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   cpu_addr = '0;
   logic [7:0]    cpu_wdata = '0;
   logic          cpu_rd = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [7:0]    cpu_rdata;
   logic [AW-1:0] dram_addr;
   logic          dram_sel;
   logic          dram_we;

   int total = 0;
   int bad = 0;
   logic [15:0] exp_page [15];

   always #10 clk = ~clk;

   dram_window_mapper i_dram_window_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .dram_addr(dram_addr), .dram_sel(dram_sel), .dram_we(dram_we)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr(input logic [15:0] a);
      return {exp_page[a[15:12]][PB-1:0], a[11:0]};
   endfunction

   // One-cycle bus write; takes effect at the clock edge inside it.
   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic reg_write(input int w, input bit hi, input logic [7:0] d);
      bus_write(16'hFF00 + 16'(2*w) + 16'(hi), d);
      if (hi) exp_page[w][15:8] = d; else exp_page[w][7:0] = d;
   endtask

   // Drive one access, sample before the next edge, then release.
   task automatic drive(input logic [15:0] a, input bit rd, input bit wr);
      @(negedge clk);
      cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h3C;
      #2;
   endtask

   task automatic release_bus;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic t_reset_identity;
      for (int w = 0; w < 15; w += 3) begin
         drive(16'(w << 12) | 16'h0A5, 1'b1, 1'b0);
         check("R1", "reset identity addr", 32'(dram_addr), 32'({PB'(w), 12'h0A5}));
         check("R3", "read select", 32'(dram_sel), 32'd1);
         check("R10", "read gives no we", 32'(dram_we), 32'd0);
      end
      drive(16'h0000, 1'b0, 1'b0);
      check("R3", "idle select", 32'(dram_sel), 32'd0);
      release_bus();
   endtask

   task automatic t_top_window;
      drive(16'hF123, 1'b1, 1'b0);
      check("R2", "top read sel", 32'({dram_sel, dram_we}), 32'd0);
      drive(16'hFF80, 1'b0, 1'b1);
      check("R2", "top write sel", 32'({dram_sel, dram_we}), 32'd0);
      release_bus();
   endtask

   task automatic t_remap;
      reg_write(3, 1'b0, 8'h5A);
      reg_write(3, 1'b1, 8'h02);
      drive(16'h3ABC, 1'b1, 1'b0);
      check("R4", "remapped window 3", 32'(dram_addr), 32'(exp_addr(16'h3ABC)));
      drive(16'h3001, 1'b0, 1'b1);
      check("R3", "write addr", 32'(dram_addr), 32'({PB'(10'h25A), 12'h001}));
      check("R7", "we after reset", 32'(dram_we), 32'd1);
      release_bus();
   endtask

   task automatic t_readback;
      drive(16'hFF06, 1'b1, 1'b0);
      check("R5", "low byte readback", 32'(cpu_rdata), 32'h5A);
      drive(16'hFF07, 1'b1, 1'b0);
      check("R5", "high byte readback", 32'(cpu_rdata), 32'h02);
      drive(16'hFF1C, 1'b1, 1'b0);
      check("R5", "last reg low byte", 32'(cpu_rdata), 32'h0E);
      drive(16'hFF1E, 1'b1, 1'b0);
      check("R5", "past last reg", 32'(cpu_rdata), 32'h00);
      drive(16'hFF06, 1'b0, 1'b0);
      check("R5", "no read strobe", 32'(cpu_rdata), 32'h00);
      release_bus();
   endtask

   task automatic t_byte_isolation;
      reg_write(5, 1'b1, 8'h01);
      drive(16'hFF0A, 1'b1, 1'b0);
      check("R9", "low byte untouched", 32'(cpu_rdata), 32'h05);
      drive(16'hFF08, 1'b1, 1'b0);
      check("R9", "neighbour low", 32'(cpu_rdata), 32'h04);
      drive(16'hFF0C, 1'b1, 1'b0);
      check("R9", "neighbour above", 32'(cpu_rdata), 32'h06);
      drive(16'h5FFF, 1'b1, 1'b0);
      check("R9", "window 5 page", 32'(dram_addr), 32'(exp_addr(16'h5FFF)));
      release_bus();
   endtask

   task automatic t_truncate;
      reg_write(7, 1'b0, 8'h11);
      reg_write(7, 1'b1, 8'hFC);
      drive(16'h7000, 1'b0, 1'b1);
      check("R8", "upper bits dropped", 32'(dram_addr), 32'({PB'(10'h011), 12'h000}));
      drive(16'hFF0F, 1'b1, 1'b0);
      check("R8", "upper bits kept", 32'(cpu_rdata), 32'hFC);
      release_bus();
   endtask

   task automatic t_block_allow;
      bus_write(16'hFFC0, 8'h00);
      drive(16'h3010, 1'b0, 1'b1);
      check("R6", "blocked write sel", 32'(dram_sel), 32'd1);
      check("R6", "blocked write we", 32'(dram_we), 32'd0);
      drive(16'h3010, 1'b1, 1'b0);
      check("R6", "read while blocked", 32'(dram_addr), 32'(exp_addr(16'h3010)));
      drive(16'h0400, 1'b0, 1'b1);
      check("R6", "still blocked", 32'(dram_we), 32'd0);
      release_bus();
      bus_write(16'hFFC1, 8'hA5);
      drive(16'h0400, 1'b0, 1'b1);
      check("R7", "write re-allowed", 32'(dram_we), 32'd1);
      release_bus();
   endtask

   initial begin
      for (int w = 0; w < 15; w++) exp_page[w] = 16'(w);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_identity();
      t_top_window();
      t_remap();
      t_readback();
      t_byte_isolation();
      t_truncate();
      t_block_allow();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule